// File: doc/BRIEF.md
# UART Receive Queue with Trigger-Level Interrupt

This block is the receive-side character queue of a UART channel. The deserializer delivers each received character with three error flags: parity, framing and break. The block stores the character and its flags in a first-in first-out queue. A host reads the character at the head of the queue, and that read removes it. The host can also read the current fill count and the receive half of the line status byte.

The host writes a trigger threshold that is a full byte wide. While the fill count is at or above the effective threshold, a data-available status bit is high. If the receive interrupt enable is set, a level-sensitive interrupt output follows that bit. When all four interrupt enable bits are clear, the block runs in polled mode: the status bits keep updating, but the interrupt output stays low.

The line status byte holds these receive bits:
- data ready
- overrun
- the three error flags of the head character
- a queue-wide flag that is set while any stored character carries an error

The error flags of the head character and the queue-wide flag are reported separately.

Top module: `uart_rx_fifo_trig`

## Requirements
- R1: Characters leave in the order they arrived. `rx_count` gives the number stored, from 0 to 64. A head read on an empty queue has no effect, and pushing and popping in the same cycle leaves the count unchanged.
- R2: `lsr[0]` (data ready) goes high in the cycle after a character is accepted. It stays high until the queue is empty.
- R3: `rda_status` is high exactly while `rx_count` is at or above the effective trigger. It falls as soon as a pop takes the count below that value.
- R4: The effective trigger is the written trigger value, with two exceptions: a written 0 acts as 1, and a value above 64 acts as 64. The trigger value after reset is 1.
- R5: A push on a full queue in a cycle with no pop is dropped, and the stored characters stay unchanged. Such a push sets `lsr[1]` (overrun). An `lsr` read strobe clears that bit on the next cycle, unless a new overrun occurs in the same cycle, in which case the bit stays set.
- R6: `lsr[2]` is parity, `lsr[3]` is framing and `lsr[4]` is break. These bits show the flags of the head character and read 0 when the queue is empty. `lsr[6:5]` always read 0.
- R7: `lsr[7]` is high while at least one stored character has any of its error flags set.
- R8: `irq_rda` equals `rda_status` AND `ier[0]`. With `ier` = 0 (polled mode), `irq_rda` stays low while the status bits keep updating.
- R9: While `fifo_en` is low, the effective trigger is 1, whatever value was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | A character from the shift register is offered this cycle |
| push_data | input | 8 | Received character |
| push_par_err | input | 1 | Parity error flag of the character |
| push_frm_err | input | 1 | Framing error flag of the character |
| push_brk | input | 1 | Break flag of the character |
| fifo_en | input | 1 | Queue enable; low forces the trigger to 1 |
| ier | input | 4 | Interrupt enable bits; bit 0 enables the receive interrupt |
| bus_rd_data | input | 1 | Host read of the head character; pops it |
| bus_rd_lsr | input | 1 | Host read of the line status; clears overrun |
| bus_wr_trig | input | 1 | Host write strobe for the trigger value |
| bus_wdata | input | 8 | Host write data |
| head_data | output | 8 | Character at the head of the queue |
| rx_count | output | 8 | Current fill count |
| lsr | output | 8 | Receive line status byte |
| rda_status | output | 1 | Data-available status |
| irq_rda | output | 1 | Level-sensitive receive interrupt |

## Verification
The assertions check the following on every cycle:
- `rx_count` stays within range.
- A pop on an empty queue leaves the count at zero.
- Data ready tracks a non-empty queue.
- A push on a full queue sets overrun and leaves the count at 64.
- The head-error bits are zero when the queue is empty, and a head error always implies the queue-wide flag.
- The interrupt is gated by the enable bits.

Some properties need particular sequences of data and cannot be written as single-cycle rules, so only the bench scenarios show them:
- first-in first-out order of the data
- that overrun leaves the stored contents unchanged
- the exact count at which the trigger fires for the 0 and above-depth saturation cases
- that the queue-wide error flag falls only when the last errored character leaves

// File: rtl/rxf_pkg.sv
// Package: shared types for the receive queue.
// Assumes: error flags travel with each character as one packed group.
package rxf_pkg;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxf_err_t;

    localparam int RXF_ERRW = 3;

endpackage

// File: rtl/rxf_storage.sv
// Module: rxf_storage
// Circular buffer for characters and their error flags, with pointers and
// an occupancy count. A push is accepted when the buffer is not full, or
// when a pop happens in the same cycle. A pop is accepted when the buffer
// is not empty.
// Assumes: DEPTH is a power of two, so the pointers wrap on their own.
module rxf_storage
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  rxf_err_t      wr_err,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [DW-1:0] head_data,
    output rxf_err_t      head_err,
    output logic [CW-1:0] count,
    output logic          empty
);

    localparam int EW = DW + RXF_ERRW;

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full;

    // Full and empty flags from the occupancy count.
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    // Accept a pop only when the buffer has data; accept a push when space
    // exists now or is freed by a pop in this cycle.
    assign rd_ok = rd_req && !empty;
    assign wr_ok = wr_req && (!full || rd_ok);

    // Write the accepted character into the storage array.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= {wr_err, wr_data};
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            if (wr_ok && !rd_ok)      count <= count + 1'b1;
            else if (rd_ok && !wr_ok) count <= count - 1'b1;
        end
    end

    // Present the head entry; its error flags are masked when the buffer is empty.
    always_comb begin
        head_data = mem[rd_ptr][DW-1:0];
        head_err  = empty ? '0 : rxf_err_t'(mem[rd_ptr][EW-1:DW]);
    end

endmodule

// File: rtl/rxf_trigger.sv
// Module: rxf_trigger
// Holds the host-written trigger value, maps it to an effective threshold
// and compares the threshold with the fill count.
// Assumes: DEPTH fits within the trigger width.
module rxf_trigger #(
    parameter int DEPTH = 64,
    parameter int TW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_val,
    input  logic          fifo_en,
    input  logic [CW-1:0] count,
    output logic          rda
);

    logic [TW-1:0] trig_q;
    logic [TW-1:0] eff;
    logic [TW:0]   cnt_x;

    // Store the trigger value written by the host; it resets to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)     trig_q <= TW'(1);
        else if (wr_en) trig_q <= wr_val;
    end

    // Apply the enable override and the saturation to get the effective threshold.
    always_comb begin
        if (!fifo_en || trig_q == '0)  eff = TW'(1);
        else if (trig_q > TW'(DEPTH))  eff = TW'(DEPTH);
        else                           eff = trig_q;
    end

    // Compare the count with the threshold at a common width.
    assign cnt_x = (TW + 1)'(count);
    assign rda   = (cnt_x >= {1'b0, eff});

endmodule

// File: rtl/rxf_status.sv
// Module: rxf_status
// Builds the receive half of the line status byte. It keeps the sticky
// overrun bit and a count of stored characters that carry errors.
// Assumes: the accept strobes come from the storage block in the same cycle.
module rxf_status
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_req,
    input  logic     wr_ok,
    input  logic     rd_ok,
    input  rxf_err_t wr_err,
    input  rxf_err_t head_err,
    input  logic     empty,
    input  logic     lsr_rd,
    output logic [7:0] lsr
);

    logic          ovr_q;
    logic [CW-1:0] err_cnt;
    logic          in_bad, out_bad;

    assign in_bad  = wr_ok && (wr_err != '0);
    assign out_bad = rd_ok && (head_err != '0);

    // Sticky overrun: a dropped push sets it, a status read clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovr_q <= 1'b0;
        else if (wr_req && !wr_ok) ovr_q <= 1'b1;
        else if (lsr_rd)           ovr_q <= 1'b0;
    end

    // Count the stored characters that carry any error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_cnt <= '0;
        else if (in_bad && !out_bad) err_cnt <= err_cnt + 1'b1;
        else if (out_bad && !in_bad) err_cnt <= err_cnt - 1'b1;
    end

    // Assemble the status byte; bits 6:5 belong to the transmit side and read 0.
    always_comb begin
        lsr    = '0;
        lsr[0] = !empty;
        lsr[1] = ovr_q;
        lsr[2] = head_err.par;
        lsr[3] = head_err.frm;
        lsr[4] = head_err.brk;
        lsr[7] = (err_cnt != '0);
    end

endmodule

// File: rtl/uart_rx_fifo_trig.sv
// Module: uart_rx_fifo_trig
// Receive queue of a UART channel with a trigger-level interrupt and
// receive line status. Reading the head character pops it.
// Assumes: DEPTH is a power of two and no larger than 255.
module uart_rx_fifo_trig
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int TW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          push_par_err,
    input  logic          push_frm_err,
    input  logic          push_brk,
    input  logic          fifo_en,
    input  logic [3:0]    ier,
    input  logic          bus_rd_data,
    input  logic          bus_rd_lsr,
    input  logic          bus_wr_trig,
    input  logic [TW-1:0] bus_wdata,
    output logic [DW-1:0] head_data,
    output logic [7:0]    rx_count,
    output logic [7:0]    lsr,
    output logic          rda_status,
    output logic          irq_rda
);

    rxf_err_t      in_err, head_err;
    logic          wr_ok, rd_ok, empty;
    logic [CW-1:0] count;

    assign in_err = '{brk: push_brk, frm: push_frm_err, par: push_par_err};

    rxf_storage #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (push_valid),
        .wr_data   (push_data),
        .wr_err    (in_err),
        .rd_req    (bus_rd_data),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .head_data (head_data),
        .head_err  (head_err),
        .count     (count),
        .empty     (empty)
    );

    rxf_trigger #(.DEPTH(DEPTH), .TW(TW)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_trig),
        .wr_val  (bus_wdata),
        .fifo_en (fifo_en),
        .count   (count),
        .rda     (rda_status)
    );

    rxf_status #(.DEPTH(DEPTH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (push_valid),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok),
        .wr_err   (in_err),
        .head_err (head_err),
        .empty    (empty),
        .lsr_rd   (bus_rd_lsr),
        .lsr      (lsr)
    );

    // Pad the count to the byte-wide register when it is narrower.
    generate
        if (CW < 8) begin : g_pad
            assign rx_count = {{(8 - CW){1'b0}}, count};
        end else begin : g_full
            assign rx_count = 8'(count);
        end
    endgenerate

    // The interrupt follows the status bit only while the receive enable is set.
    assign irq_rda = rda_status && ier[0];

endmodule

// File: rtl/rxf_checker.sv
// Module: rxf_checker
// Port-level properties for uart_rx_fifo_trig, attached with bind.
module rxf_checker #(
    parameter int DEPTH = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       push_valid,
    input logic       bus_rd_data,
    input logic [3:0] ier,
    input logic [7:0] rx_count,
    input logic [7:0] lsr,
    input logic       rda_status,
    input logic       irq_rda
);

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= 8'(DEPTH)); // R1
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == 8'd0 && bus_rd_data && !push_valid) |=> (rx_count == 8'd0)); // R1
    AST_READY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> lsr[0]); // R2
    AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[0] == (rx_count != 8'd0)); // R2
    AST_RDA_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rda_status |-> (rx_count != 8'd0)); // R3
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && rx_count == 8'(DEPTH) && !bus_rd_data) |=> lsr[1]); // R5
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && rx_count == 8'(DEPTH) && !bus_rd_data) |=> (rx_count == 8'(DEPTH))); // R5
    AST_HEAD_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == 8'd0) |-> (lsr[4:2] == 3'b000)); // R6
    AST_TX_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6:5] == 2'b00); // R6
    AST_ANY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[4:2] != 3'b000) |-> lsr[7]); // R7
    AST_POLLED: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'd0) |-> !irq_rda); // R8
    AST_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rda |-> rda_status); // R8

endmodule

bind uart_rx_fifo_trig rxf_checker #(.DEPTH(DEPTH)) u_rxf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_valid  (push_valid),
    .bus_rd_data (bus_rd_data),
    .ier         (ier),
    .rx_count    (rx_count),
    .lsr         (lsr),
    .rda_status  (rda_status),
    .irq_rda     (irq_rda)
);

// File: tb/test_uart_rx_fifo_trig.sv
// Directed bench for uart_rx_fifo_trig: one task per scenario.
module test_uart_rx_fifo_trig;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       push_par_err = 1'b0, push_frm_err = 1'b0, push_brk = 1'b0;
    logic       fifo_en = 1'b1;
    logic [3:0] ier = 4'd1;
    logic       bus_rd_data = 1'b0, bus_rd_lsr = 1'b0, bus_wr_trig = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] head_data, rx_count, lsr;
    logic       rda_status, irq_rda;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_rx_fifo_trig i_uart_rx_fifo_trig (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_par_err(push_par_err), .push_frm_err(push_frm_err), .push_brk(push_brk),
        .fifo_en(fifo_en), .ier(ier), .bus_rd_data(bus_rd_data), .bus_rd_lsr(bus_rd_lsr),
        .bus_wr_trig(bus_wr_trig), .bus_wdata(bus_wdata), .head_data(head_data),
        .rx_count(rx_count), .lsr(lsr), .rda_status(rda_status), .irq_rda(irq_rda)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
        @(negedge clk);
        push_valid = 1'b1; push_data = d;
        push_par_err = p; push_frm_err = f; push_brk = b;
        @(negedge clk);
        push_valid = 1'b0; push_par_err = 1'b0; push_frm_err = 1'b0; push_brk = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        bus_rd_data = 1'b1;
        @(negedge clk);
        bus_rd_data = 1'b0;
    endtask

    task automatic set_trig(input logic [7:0] v);
        @(negedge clk);
        bus_wr_trig = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr_trig = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 70; i++) if (rx_count != 0) pop();
    endtask

    task automatic t_reset();
        chk("R1 reset count", rx_count, 0);
        chk("R2 reset lsr", lsr, 8'h00);
        chk("R3 reset rda", rda_status, 0);
        chk("R8 reset irq", irq_rda, 0);
    endtask

    task automatic t_order();
        pop();
        chk("R1 pop on empty", rx_count, 0);
        push(8'h5A, 0, 0, 0);
        chk("R2 data ready after push", lsr[0], 1);
        push(8'hC3, 0, 0, 0);
        push(8'h07, 0, 0, 0);
        chk("R1 count 3", rx_count, 3);
        chk("R1 head 1st", head_data, 8'h5A); pop();
        chk("R1 head 2nd", head_data, 8'hC3); pop();
        chk("R2 still ready", lsr[0], 1);
        chk("R1 head 3rd", head_data, 8'h07); pop();
        chk("R2 ready clears empty", lsr[0], 0);
    endtask

    task automatic t_same_cycle();
        push(8'h10, 0, 0, 0);
        @(negedge clk);
        push_valid = 1'b1; push_data = 8'h20; bus_rd_data = 1'b1;
        @(negedge clk);
        push_valid = 1'b0; bus_rd_data = 1'b0;
        chk("R1 push+pop count", rx_count, 1);
        chk("R1 push+pop head", head_data, 8'h20);
        drain();
    endtask

    task automatic t_trigger();
        set_trig(8'd4); ier = 4'd1;
        for (int i = 0; i < 3; i++) push(8'(i), 0, 0, 0);
        chk("R3 below trigger", rda_status, 0);
        chk("R8 irq below trigger", irq_rda, 0);
        push(8'h33, 0, 0, 0);
        chk("R3 at trigger", rda_status, 1);
        chk("R8 irq at trigger", irq_rda, 1);
        pop();
        chk("R3 drop below", rda_status, 0);
        chk("R8 irq drop", irq_rda, 0);
        drain();
    endtask

    task automatic t_saturate();
        set_trig(8'd0);
        push(8'h01, 0, 0, 0);
        chk("R4 zero acts as one", rda_status, 1);
        drain();
        set_trig(8'd200);
        for (int i = 0; i < 63; i++) push(8'(i), 0, 0, 0);
        chk("R4 sat below 64", rda_status, 0);
        push(8'h3F, 0, 0, 0);
        chk("R4 sat at 64", rda_status, 1);
        drain();
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        set_trig(8'd1);
        for (int i = 0; i < 64; i++) push(8'(i + 8'h40), 0, 0, 0);
        chk("R5 full count", rx_count, 64);
        chk("R5 no overrun yet", lsr[1], 0);
        push(8'hAA, 1, 0, 0);
        chk("R5 overrun set", lsr[1], 1);
        chk("R5 count unchanged", rx_count, 64);
        chk("R5 head unchanged", head_data, 8'h40);
        chk("R7 dropped error not counted", lsr[7], 0);
        @(negedge clk);
        bus_rd_lsr = 1'b1; v = lsr;
        @(negedge clk);
        bus_rd_lsr = 1'b0;
        chk("R5 read value", v[1], 1);
        chk("R5 cleared by read", lsr[1], 0);
        for (int i = 0; i < 63; i++) pop();
        chk("R5 last kept char", head_data, 8'h7F);
        pop();
        chk("R5 drained", rx_count, 0);
    endtask

    task automatic t_errors();
        push(8'h11, 0, 0, 0);
        push(8'h22, 1, 0, 0);
        push(8'h33, 0, 1, 0);
        push(8'h44, 0, 0, 1);
        chk("R7 any error with clean head", lsr, 8'h81);
        pop();
        chk("R6 parity head", lsr, 8'h85);
        pop();
        chk("R6 framing head", lsr, 8'h89);
        pop();
        chk("R6 break head", lsr, 8'h91);
        pop();
        chk("R7 error flag gone", lsr, 8'h00);
        push(8'h55, 1, 0, 0);
        push(8'h66, 0, 0, 0);
        pop();
        chk("R7 falls after last errored", lsr, 8'h01);
        drain();
    endtask

    task automatic t_polled();
        set_trig(8'd1); ier = 4'd0;
        push(8'h77, 0, 0, 0);
        chk("R8 polled status", rda_status, 1);
        chk("R8 polled no irq", irq_rda, 0);
        ier = 4'd2;
        @(negedge clk);
        chk("R8 other enable no irq", irq_rda, 0);
        ier = 4'd1;
        @(negedge clk);
        chk("R8 enabled irq", irq_rda, 1);
        drain();
    endtask

    task automatic t_disabled();
        set_trig(8'd8); fifo_en = 1'b0;
        push(8'h12, 0, 0, 0);
        chk("R9 disabled trigger one", rda_status, 1);
        fifo_en = 1'b1;
        @(negedge clk);
        chk("R9 enabled trigger eight", rda_status, 0);
        drain();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_same_cycle();
        t_trigger();
        t_saturate();
        t_overrun();
        t_errors();
        t_polled();
        t_disabled();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule